// File: doc/BRIEF.md
# Double-Buffered Endpoint Receive FIFO

This block is the receive-side packet store for a single endpoint. A packet engine pushes bytes in one at a time and marks the end of each packet. The CPU drains the stored packet through one data port. Each read strobe moves it to the next byte. The byte count of the packet at the head is shown as a low byte and a high byte. The high byte is captured when the low byte is read, so the CPU always reads two halves of the same count.

A maximum packet size is sampled when the endpoint enable rises. If that size fits in half of the storage, the store splits into two halves that are used in ping-pong order, so the engine can fill one half while the CPU drains the other. Otherwise the whole store holds one packet. The CPU hands a packet back by pulsing a release input. When a second packet is already waiting at that moment, the ready flag drops for one clock and then rises again for the newer packet. Bytes that arrive while no half is free, or that do not fit in the current half, are discarded and raise a sticky overflow flag. A synchronous flush empties everything.

Top module: `rxPktFifo`

## Requirements
- R1: On a rising edge of `epEnable`, the block picks two-half mode if `maxPktSize` <= DEPTH/2 and one-buffer mode otherwise. In two-half mode `wrBusy` stays low after one finished packet and goes high after two. In one-buffer mode `wrBusy` goes high after one. `wrBusy` is also high while `epEnable` is low.
- R2: `cntLo` shows bits 7..0 of the head packet's byte count. One cycle after a `cpuRdCntLo` pulse, `cntHi` holds count bits 9..8 in its bits 1..0, and its bits 7..2 are zero.
- R3: `cntHi` changes only on a `cpuRdCntLo` pulse, on flush or on reset. Releasing a packet leaves it unchanged.
- R4: In two-half mode, packets are presented in arrival order. The older packet's count and data come first, and after release the newer packet's count and data follow.
- R5: `dataOut` shows the head packet's byte at the read position, starting at its first byte. Each `cpuRdData` pulse moves to the next byte.
- R6: In two-half mode, if the CPU releases the head packet while the other half holds a finished packet, `pktReady` is low for exactly one cycle and then high again.
- R7: If the CPU releases the head packet while no other finished packet is stored, `pktReady` goes low on the next cycle and `cntLo` reads 0.
- R8: A byte written while `wrBusy` is high is discarded and sets `overflow`. `overflow` stays set until flush or reset.
- R9: A byte beyond the current buffer's capacity (DEPTH/2 in two-half mode, DEPTH in one-buffer mode) is discarded and sets `overflow`. The packet's count stops at that capacity.
- R10: One cycle after a `flush` pulse, `pktReady` and `overflow` are low and `cntLo` and `cntHi` are zero.
- R11: After reset, `pktReady` and `overflow` are low, `cntLo` and `cntHi` are zero, and `wrBusy` is high while `epEnable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Synchronous empty of both buffers |
| epEnable | input | 1 | Endpoint enable; rising edge samples the mode |
| maxPktSize | input | CNT_W | Configured maximum packet size |
| wrValid | input | 1 | Receive engine byte strobe |
| wrData | input | 8 | Receive engine byte |
| wrEnd | input | 1 | Receive engine end-of-packet strobe |
| wrBusy | output | 1 | No buffer free for the engine |
| overflow | output | 1 | Sticky: a byte was discarded |
| cpuRdData | input | 1 | Advance to next data byte |
| dataOut | output | 8 | Byte at the read position |
| cpuRdCntLo | input | 1 | Low count read; captures the high byte |
| cntLo | output | 8 | Count bits 7..0 of head packet |
| cntHi | output | 8 | Captured count bits 9..8, upper bits zero |
| cpuClrRdy | input | 1 | Release the head packet |
| pktReady | output | 1 | A finished packet is at the head |

## Verification
A wrong full flag or half select shows up at once on `wrBusy` and `pktReady`. Within one packet it also shows as counts or bytes from the wrong half, or as packets out of order. A fault in the read pointer or the write address corrupts `dataOut` at the first byte read after the fault. A wrong high-byte capture shows on `cntHi` one cycle after the low read, or as a change on release. Loss of the one-cycle gap, or a gap that lasts too long, shows on `pktReady` in the two cycles after release.

// File: rtl/rxfifo_pkg.sv
package rxfifo_pkg;
  typedef struct packed {
    logic memWr;
    logic endPkt;
    logic rdPtrInc;
    logic relPkt;
    logic latchHi;
    logic clear;
  } fifoStrobe_t;
endpackage

// File: rtl/rxfifo_datapath.sv
module rxfifo_datapath
  import rxfifo_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strb,
  input  logic             wrSel,
  input  logic             rdSel,
  input  logic             dblMode,
  input  logic [7:0]       wrData,
  output logic             wrRoom,
  output logic [7:0]       dataOut,
  output logic [7:0]       cntLo,
  output logic [7:0]       cntHi
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  logic [7:0]       mem [DEPTH];
  logic [PW-1:0]    wrPtr;
  logic [PW-1:0]    rdPtr;
  logic [CNT_W-1:0] cnt [2];
  logic [7:0]       hiReg;
  logic [PW-1:0]    capacity;
  logic [AW-1:0]    wrAddr;
  logic [AW-1:0]    rdAddr;
  logic [AW-1:0]    wrBase;
  logic [AW-1:0]    rdBase;

  always_comb begin
    capacity = dblMode ? PW'(HALF) : PW'(DEPTH);
    wrRoom   = wrPtr < capacity;
    wrBase   = (dblMode && wrSel) ? AW'(HALF) : '0;
    rdBase   = (dblMode && rdSel) ? AW'(HALF) : '0;
    wrAddr   = wrBase + wrPtr[AW-1:0];
    rdAddr   = rdBase + rdPtr[AW-1:0];
    dataOut  = mem[rdAddr];
    cntLo    = cnt[rdSel][7:0];
    cntHi    = hiReg;
  end

  always_ff @(posedge clk) begin
    if (strb.memWr) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      wrPtr <= '0;
    end else if (strb.endPkt) begin
      wrPtr <= '0;
    end else if (strb.memWr) begin
      wrPtr <= wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      rdPtr <= '0;
    end else if (strb.relPkt) begin
      rdPtr <= '0;
    end else if (strb.rdPtrInc) begin
      rdPtr <= rdPtr + 1'b1;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN || strb.clear) begin
        cnt[b] <= '0;
      end else if (strb.endPkt && (wrSel == b[0])) begin
        cnt[b] <= CNT_W'(wrPtr) + CNT_W'(strb.memWr);
      end else if (strb.relPkt && (rdSel == b[0])) begin
        cnt[b] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      hiReg <= '0;
    end else if (strb.latchHi) begin
      hiReg <= 8'(cnt[rdSel] >> 8);
    end
  end
endmodule

// File: rtl/rxfifo_control.sv
module rxfifo_control
  import rxfifo_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             epEnable,
  input  logic [CNT_W-1:0] maxPktSize,
  input  logic             wrValid,
  input  logic             wrEnd,
  input  logic             cpuRdData,
  input  logic             cpuRdCntLo,
  input  logic             cpuClrRdy,
  input  logic             wrRoom,
  output fifoStrobe_t      strb,
  output logic             wrSel,
  output logic             rdSel,
  output logic             dblMode,
  output logic [1:0]       bufFull,
  output logic             pktReady,
  output logic             wrBusy,
  output logic             overflow
);
  localparam int HALF = DEPTH / 2;

  logic enPrev;
  logic gap;
  logic enRise;
  logic relOk;

  always_comb begin
    enRise        = epEnable && !enPrev;
    wrBusy        = !epEnable || bufFull[wrSel];
    pktReady      = bufFull[rdSel] && !gap;
    relOk         = cpuClrRdy && bufFull[rdSel] && !flush;
    strb.clear    = flush;
    strb.memWr    = wrValid && !wrBusy && wrRoom && !flush;
    strb.endPkt   = wrEnd && !wrBusy && !flush;
    strb.rdPtrInc = cpuRdData && bufFull[rdSel] && !flush;
    strb.relPkt   = relOk;
    strb.latchHi  = cpuRdCntLo && !flush;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enPrev  <= 1'b0;
      dblMode <= 1'b0;
    end else begin
      enPrev <= epEnable;
      if (enRise) dblMode <= (maxPktSize <= CNT_W'(HALF));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      bufFull  <= '0;
      wrSel    <= 1'b0;
      rdSel    <= 1'b0;
      gap      <= 1'b0;
      overflow <= 1'b0;
    end else begin
      gap <= 1'b0;
      if (wrValid && (wrBusy || !wrRoom)) overflow <= 1'b1;
      if (strb.endPkt) begin
        bufFull[wrSel] <= 1'b1;
        if (dblMode) wrSel <= !wrSel;
      end
      if (relOk) begin
        bufFull[rdSel] <= 1'b0;
        if (dblMode) begin
          rdSel <= !rdSel;
          gap   <= bufFull[!rdSel];
        end
      end
      if (enRise) begin
        wrSel <= 1'b0;
        rdSel <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxPktFifo.sv
module rxPktFifo
  import rxfifo_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             epEnable,
  input  logic [CNT_W-1:0] maxPktSize,
  input  logic             wrValid,
  input  logic [7:0]       wrData,
  input  logic             wrEnd,
  output logic             wrBusy,
  output logic             overflow,
  input  logic             cpuRdData,
  output logic [7:0]       dataOut,
  input  logic             cpuRdCntLo,
  output logic [7:0]       cntLo,
  output logic [7:0]       cntHi,
  input  logic             cpuClrRdy,
  output logic             pktReady
);
  fifoStrobe_t strb;
  logic        wrSel;
  logic        rdSel;
  logic        dblMode;
  logic [1:0]  bufFull;
  logic        wrRoom;

  rxfifo_control #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .epEnable(epEnable),
    .maxPktSize(maxPktSize), .wrValid(wrValid), .wrEnd(wrEnd),
    .cpuRdData(cpuRdData), .cpuRdCntLo(cpuRdCntLo), .cpuClrRdy(cpuClrRdy),
    .wrRoom(wrRoom), .strb(strb), .wrSel(wrSel), .rdSel(rdSel),
    .dblMode(dblMode), .bufFull(bufFull), .pktReady(pktReady),
    .wrBusy(wrBusy), .overflow(overflow)
  );

  rxfifo_datapath #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrSel(wrSel), .rdSel(rdSel),
    .dblMode(dblMode), .wrData(wrData), .wrRoom(wrRoom),
    .dataOut(dataOut), .cntLo(cntLo), .cntHi(cntHi)
  );
endmodule

// File: rtl/rxPktFifo_chk.sv
module rxPktFifo_chk (
  input logic       clk,
  input logic       rstN,
  input logic       flush,
  input logic       wrValid,
  input logic       wrEnd,
  input logic       cpuClrRdy,
  input logic       cpuRdCntLo,
  input logic       pktReady,
  input logic       wrBusy,
  input logic       overflow,
  input logic [7:0] cntLo,
  input logic [7:0] cntHi,
  input logic [1:0] bufFull,
  input logic       dblMode
);
  // R6
  gap_pulse_chk: assert property (@(posedge clk) disable iff (!rstN || flush)
    (pktReady && cpuClrRdy && dblMode && bufFull == 2'b11) |=> (!pktReady ##1 pktReady));

  // R7
  lone_release_chk: assert property (@(posedge clk) disable iff (!rstN || flush)
    (pktReady && cpuClrRdy && !wrEnd && !(dblMode && bufFull == 2'b11)) |=> !pktReady);

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rstN || flush)
    (wrValid && wrBusy) |=> overflow);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN || flush)
    overflow |=> overflow);

  // R3
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rstN || flush)
    !cpuRdCntLo |=> $stable(cntHi));

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!pktReady && !overflow && cntLo == 8'd0 && cntHi == 8'd0));

  // R2
  always_comb begin
    if (rstN) hi_upper_zero_chk: assert (cntHi[7:2] == 6'd0);
  end
endmodule

bind rxPktFifo rxPktFifo_chk u_chk (
  .clk(clk), .rstN(rstN), .flush(flush), .wrValid(wrValid), .wrEnd(wrEnd),
  .cpuClrRdy(cpuClrRdy), .cpuRdCntLo(cpuRdCntLo), .pktReady(pktReady),
  .wrBusy(wrBusy), .overflow(overflow), .cntLo(cntLo), .cntHi(cntHi),
  .bufFull(bufFull), .dblMode(dblMode)
);

// File: tb/rxPktFifo_bench.sv
`timescale 1ns/1ps
module rxPktFifo_bench;
  localparam int DEPTH = 512;
  localparam int CNT_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic epEnable = 1'b0;
  logic [CNT_W-1:0] maxPktSize = '0;
  logic wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic wrEnd = 1'b0;
  logic wrBusy, overflow, pktReady;
  logic cpuRdData = 1'b0;
  logic cpuRdCntLo = 1'b0;
  logic cpuClrRdy = 1'b0;
  logic [7:0] dataOut, cntLo, cntHi;

  int total = 0;
  int bad = 0;
  logic [7:0] expData [2][DEPTH];

  always #5 clk = ~clk;

  rxPktFifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxPktFifo (
    .clk(clk), .rstN(rstN), .flush(flush), .epEnable(epEnable),
    .maxPktSize(maxPktSize), .wrValid(wrValid), .wrData(wrData), .wrEnd(wrEnd),
    .wrBusy(wrBusy), .overflow(overflow), .cpuRdData(cpuRdData),
    .dataOut(dataOut), .cpuRdCntLo(cpuRdCntLo), .cntLo(cntLo), .cntHi(cntHi),
    .cpuClrRdy(cpuClrRdy), .pktReady(pktReady)
  );

  function automatic int expLo(int n);
    return n & 255;
  endfunction

  function automatic int expHi(int n);
    return (n >> 8) & 3;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendPkt(int len, int slot, bit doEnd);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      wrValid = 1'b1;
      wrData  = 8'($urandom);
      if (i < DEPTH) expData[slot][i] = wrData;
    end
    @(negedge clk);
    wrValid = 1'b0;
    if (doEnd) begin
      wrEnd = 1'b1;
      @(negedge clk);
      wrEnd = 1'b0;
    end
  endtask

  task automatic readPkt(int slot, int len, string req);
    int errs;
    int firstAct;
    int firstExp;
    errs = 0;
    firstAct = 0;
    firstExp = 0;
    check(pktReady == 1'b1, req, pktReady, 1);
    check(cntLo == 8'(expLo(len)), req, cntLo, expLo(len));
    @(negedge clk);
    cpuRdCntLo = 1'b1;
    @(negedge clk);
    cpuRdCntLo = 1'b0;
    check(cntHi == 8'(expHi(len)), req, cntHi, expHi(len));
    for (int i = 0; i < len; i++) begin
      if (dataOut !== expData[slot][i]) begin
        if (errs == 0) begin
          firstAct = dataOut;
          firstExp = expData[slot][i];
        end
        errs++;
      end
      cpuRdData = 1'b1;
      @(negedge clk);
    end
    cpuRdData = 1'b0;
    check(errs == 0, {req, " R5 data"}, firstAct, firstExp);
  endtask

  task automatic releasePkt();
    @(negedge clk);
    cpuClrRdy = 1'b1;
    @(negedge clk);
    cpuClrRdy = 1'b0;
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    check(pktReady == 1'b0, "R11 pktReady", pktReady, 0);
    check(overflow == 1'b0, "R11 overflow", overflow, 0);
    check(cntLo == 8'd0, "R11 cntLo", cntLo, 0);
    check(cntHi == 8'd0, "R11 cntHi", cntHi, 0);
    check(wrBusy == 1'b1, "R11 busy while disabled", wrBusy, 1);
    rstN = 1'b1;

    // R1 one-buffer mode: 300 > DEPTH/2
    @(negedge clk);
    maxPktSize = 10'd300;
    epEnable = 1'b1;
    @(negedge clk);
    check(wrBusy == 1'b0, "R1 single idle", wrBusy, 0);
    sendPkt(300, 0, 1'b1);
    check(wrBusy == 1'b1, "R1 single full", wrBusy, 1);
    // R8 byte while busy
    sendPkt(1, 1, 1'b0);
    check(overflow == 1'b1, "R8 busy drop", overflow, 1);
    readPkt(0, 300, "R2 single count");
    releasePkt();
    check(pktReady == 1'b0, "R7 lone release", pktReady, 0);
    check(cntLo == 8'd0, "R7 count cleared", cntLo, 0);
    check(cntHi == 8'd1, "R3 hi held", cntHi, 1);
    check(overflow == 1'b1, "R8 sticky", overflow, 1);
    // R10 flush
    doFlush();
    check(overflow == 1'b0, "R10 overflow", overflow, 0);
    check(cntHi == 8'd0, "R10 cntHi", cntHi, 0);
    check(pktReady == 1'b0, "R10 pktReady", pktReady, 0);

    // R9 capacity: 513 bytes into a 512-byte buffer
    sendPkt(DEPTH + 1, 0, 1'b1);
    check(overflow == 1'b1, "R9 overflow", overflow, 1);
    readPkt(0, DEPTH, "R9 count");
    releasePkt();
    doFlush();

    // two-half mode, size exactly DEPTH/2
    @(negedge clk);
    epEnable = 1'b0;
    @(negedge clk);
    maxPktSize = 10'(DEPTH / 2);
    epEnable = 1'b1;
    @(negedge clk);
    // R1 first packet fills a full half
    sendPkt(DEPTH / 2, 0, 1'b1);
    check(wrBusy == 1'b0, "R1 dbl one stored", wrBusy, 0);
    check(overflow == 1'b0, "R9 half fits", overflow, 0);
    readPkt(0, DEPTH / 2, "R4 dbl half");
    releasePkt();

    for (int it = 0; it < 24; it++) begin
      bit two;
      int lenA;
      int lenB;
      two  = ($urandom % 3) != 0;
      lenA = 1 + ($urandom % (DEPTH / 2));
      lenB = 1 + ($urandom % (DEPTH / 2));
      sendPkt(lenA, 0, 1'b1);
      if (two) begin
        sendPkt(lenB, 1, 1'b1);
        check(wrBusy == 1'b1, "R1 dbl two stored", wrBusy, 1);
        readPkt(0, lenA, "R4 older first");
        releasePkt();
        check(pktReady == 1'b0, "R6 gap low", pktReady, 0);
        @(negedge clk);
        check(pktReady == 1'b1, "R6 gap back high", pktReady, 1);
        readPkt(1, lenB, "R4 newer next");
        releasePkt();
      end else begin
        check(wrBusy == 1'b0, "R1 dbl one stored", wrBusy, 0);
        readPkt(0, lenA, "R5 single packet");
        releasePkt();
      end
      check(pktReady == 1'b0, "R7 drained", pktReady, 0);
    end
    check(overflow == 1'b0, "R8 no spurious overflow", overflow, 0);

    // R8 in two-half mode
    sendPkt(5, 0, 1'b1);
    sendPkt(7, 1, 1'b1);
    sendPkt(1, 0, 1'b0);
    check(overflow == 1'b1, "R8 dbl busy drop", overflow, 1);
    doFlush();
    check(pktReady == 1'b0, "R10 dbl pktReady", pktReady, 0);
    check(wrBusy == 1'b0, "R10 dbl freed", wrBusy, 0);

    finishRun();
  end
endmodule